// File: doc/BRIEF.md
# Four-Stage Instruction Pipeline Controller

This block sequences a small in-order processor through four stages: instruction fetch, decode with address formation, operand fetch, and execute. It runs a six-operation instruction set (load, add, subtract, increment, unconditional jump, no-operation) out of a single memory that holds both code and data, and writes results into a small register file. The pipeline detects the hazards this structure creates and resolves each one. A jump stops sequential fetch until it has executed. A load that reads memory during operand fetch takes the memory away from the fetch stage. A register dependency is resolved either by an interlock or by operand forwarding, and a parameter selects which.

To use the block, hold `run` low and write the program through the load port. Then raise `run`. Each completed instruction appears for one cycle on the retire port, which gives its address, register write enable, destination and written value. The stage occupancy vector and a debug register read port let the surrounding logic observe progress and final state.

Top module: `ipipe4_ctrl`

## Requirements
- R1: After reset all four stages are empty, `stage_busy` is 0, `ret_valid` is low, the fetch address is 0 and every register reads 0.
- R2: With default parameters an instruction word is 13 bits wide. Opcode is bits 12:10, destination bits 9:8, first source bits 7:6, second source bits 5:4 and address bits 3:0. Opcodes are: 0 no-op, 1 load (dest gets the low 8 bits of the memory word at the address field), 2 add (dest = src1 + src2), 3 subtract (dest = src1 - src2), 4 increment (dest = src1 + 1), 5 jump to the address field. Opcodes 6 and 7 behave as no-ops. Arithmetic wraps modulo 2^DW.
- R3: Without conflicts, the instruction fetched in cycle c retires in cycle c+3, and one instruction retires per cycle. In steady state all four bits of `stage_busy` (bit 0 fetch, bit 1 decode, bit 2 operand fetch, bit 3 execute) are set.
- R4: Instructions retire in program order. Each retired address is the previous one plus 1, or the target of a jump that retired just before it.
- R5: No instruction after a jump is fetched before the jump has executed. The jump target is fetched in the cycle after the jump is in execute, which leaves exactly three empty retire cycles after every jump.
- R6: In a cycle where a load occupies operand fetch, no instruction is fetched.
- R7: With FORWARD=0, an instruction whose source register is written by the instruction in execute waits one cycle in operand fetch, and a bubble enters execute.
- R8: With FORWARD=1, such a dependency costs no cycle; the execute result is passed straight to the dependent operand.
- R9: The retire port gives the address, write enable, destination and written value of each instruction. Instructions that write no register show write enable low and value 0, and leave the registers unchanged.
- R10: With `run` low no new fetch starts, while instructions already in flight still complete; afterwards `stage_busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables instruction fetch |
| load_we | input | 1 | Program memory write strobe |
| load_addr | input | AW | Program memory write address |
| load_data | input | IW | Program memory write word |
| stage_busy | output | 4 | Per-stage occupancy: bit 0 fetch, 1 decode, 2 operand fetch, 3 execute |
| ret_valid | output | 1 | An instruction completes this cycle |
| ret_pc | output | AW | Address of the completing instruction |
| ret_wen | output | 1 | Completing instruction writes a register |
| ret_rd | output | RW | Destination register |
| ret_data | output | DW | Value written (0 when none) |
| dbg_addr | input | RW | Register read address for inspection |
| dbg_data | output | DW | Register contents at `dbg_addr` |

## Verification
The assertions check four rules on every cycle. Retired addresses follow program order and jump targets. Every jump is followed by three empty execute slots. A load in operand fetch leaves the decode stage empty in the next cycle. In interlock mode every stall holds operand fetch and inserts a bubble, and in forwarding mode operand fetch always drains into execute. Exact retire cycles, written values and final register contents depend on whole instruction sequences. Only the bench's programs can show these, and it checks them against an independent timing and value model for both hazard modes at once.

// File: rtl/ipipe4_pkg.sv
package ipipe4_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LOAD = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_INC  = 3'd4,
      OP_JMP  = 3'd5
   } op_e;

   function automatic logic uses_src1(logic [2:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
   endfunction

   function automatic logic uses_src2(logic [2:0] op);
      return (op == OP_ADD) || (op == OP_SUB);
   endfunction

   function automatic logic writes_reg(logic [2:0] op);
      return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
   endfunction

   function automatic logic is_jump(logic [2:0] op);
      return op == OP_JMP;
   endfunction
endpackage

// File: rtl/ipipe4_mem.sv
module ipipe4_mem #(
   parameter int IW = 13,
   parameter int AW = 4,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [IW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [IW-1:0] rdata
);
   logic [IW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/ipipe4_regfile.sv
module ipipe4_regfile #(
   parameter int DW   = 8,
   parameter int NREG = 4,
   localparam int RW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [RW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [RW-1:0] ra,
   input  logic [RW-1:0] rb,
   input  logic [RW-1:0] rc,
   output logic [DW-1:0] qa,
   output logic [DW-1:0] qb,
   output logic [DW-1:0] qc
);
   logic [DW-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   assign qa = regs[ra];
   assign qb = regs[rb];
   assign qc = regs[rc];
endmodule

// File: rtl/ipipe4_hazard.sv
module ipipe4_hazard
   import ipipe4_pkg::*;
#(
   parameter int DW      = 8,
   parameter int RW      = 2,
   parameter int FORWARD = 1
) (
   input  logic          fo_valid,
   input  logic [2:0]    fo_op,
   input  logic [RW-1:0] fo_src1,
   input  logic [RW-1:0] fo_src2,
   input  logic          ex_valid,
   input  logic [2:0]    ex_op,
   input  logic [RW-1:0] ex_dst,
   input  logic [DW-1:0] ex_result,
   input  logic [DW-1:0] rf_a,
   input  logic [DW-1:0] rf_b,
   output logic [DW-1:0] opnd_a,
   output logic [DW-1:0] opnd_b,
   output logic          hold
);
   logic ex_wr, hit_a, hit_b;

   assign ex_wr = ex_valid && writes_reg(ex_op);
   assign hit_a = fo_valid && ex_wr && uses_src1(fo_op) && (ex_dst == fo_src1);
   assign hit_b = fo_valid && ex_wr && uses_src2(fo_op) && (ex_dst == fo_src2);

   if (FORWARD != 0) begin : g_bypass
      assign opnd_a = hit_a ? ex_result : rf_a;
      assign opnd_b = hit_b ? ex_result : rf_b;
      assign hold   = 1'b0;
   end else begin : g_interlock
      assign opnd_a = rf_a;
      assign opnd_b = rf_b;
      assign hold   = hit_a || hit_b;
   end
endmodule

// File: rtl/ipipe4_ctrl.sv
module ipipe4_ctrl
   import ipipe4_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 4,
   parameter int NREG    = 4,
   parameter int FORWARD = 1,
   localparam int RW     = $clog2(NREG),
   localparam int IW     = 3 + 3 * RW + AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load_we,
   input  logic [AW-1:0] load_addr,
   input  logic [IW-1:0] load_data,
   output logic [3:0]    stage_busy,
   output logic          ret_valid,
   output logic [AW-1:0] ret_pc,
   output logic          ret_wen,
   output logic [RW-1:0] ret_rd,
   output logic [DW-1:0] ret_data,
   input  logic [RW-1:0] dbg_addr,
   output logic [DW-1:0] dbg_data
);
   localparam int OP_LSB = IW - 3;
   localparam int RD_LSB = OP_LSB - RW;
   localparam int S1_LSB = RD_LSB - RW;
   localparam int S2_LSB = S1_LSB - RW;

   if (IW < DW) begin : g_bad_width
      $error("instruction word narrower than data word");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (FORWARD != 0 && FORWARD != 1) begin : g_bad_mode
      $error("FORWARD must be 0 or 1");
   end

   // fetch address and stage registers
   logic [AW-1:0] pc;
   logic          d_v;
   logic [AW-1:0] d_pc;
   logic [IW-1:0] d_ins;
   logic          o_v;
   logic [AW-1:0] o_pc, o_ea;
   logic [2:0]    o_op;
   logic [RW-1:0] o_rd, o_s1, o_s2;
   logic          x_v;
   logic [AW-1:0] x_pc, x_ea;
   logic [2:0]    x_op;
   logic [RW-1:0] x_rd;
   logic [DW-1:0] x_a, x_b;

   logic          fo_mem, jmp_live, hz_hold, fetch_go, ex_we;
   logic [AW-1:0] mem_addr;
   logic [IW-1:0] mem_q;
   logic [DW-1:0] rf_a, rf_b, opa, opb, ex_res;

   assign fo_mem   = o_v && (o_op == OP_LOAD);
   assign mem_addr = fo_mem ? o_ea : pc;
   assign jmp_live = (d_v && is_jump(d_ins[OP_LSB +: 3])) ||
                     (o_v && is_jump(o_op)) || (x_v && is_jump(x_op));
   assign fetch_go = run && !jmp_live && !fo_mem && !hz_hold;

   ipipe4_mem #(.IW(IW), .AW(AW)) u_mem (
      .clk(clk), .we(load_we), .waddr(load_addr), .wdata(load_data),
      .raddr(mem_addr), .rdata(mem_q));

   ipipe4_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(ex_we), .waddr(x_rd), .wdata(ex_res),
      .ra(o_s1), .rb(o_s2), .rc(dbg_addr), .qa(rf_a), .qb(rf_b), .qc(dbg_data));

   ipipe4_hazard #(.DW(DW), .RW(RW), .FORWARD(FORWARD)) u_hz (
      .fo_valid(o_v), .fo_op(o_op), .fo_src1(o_s1), .fo_src2(o_s2),
      .ex_valid(x_v), .ex_op(x_op), .ex_dst(x_rd), .ex_result(ex_res),
      .rf_a(rf_a), .rf_b(rf_b), .opnd_a(opa), .opnd_b(opb), .hold(hz_hold));

   always_comb begin
      case (x_op)
         OP_LOAD: ex_res = x_b;
         OP_ADD:  ex_res = x_a + x_b;
         OP_SUB:  ex_res = x_a - x_b;
         OP_INC:  ex_res = x_a + DW'(1);
         default: ex_res = '0;
      endcase
   end
   assign ex_we = x_v && writes_reg(x_op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= '0;
         d_v <= 1'b0;
         o_v <= 1'b0;
         x_v <= 1'b0;
      end else begin
         if (x_v && is_jump(x_op)) pc <= x_ea;
         else if (fetch_go)        pc <= pc + AW'(1);
         if (!hz_hold) begin
            d_v <= fetch_go;
            o_v <= d_v;
            x_v <= o_v;
         end else begin
            x_v <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!hz_hold) begin
         d_pc  <= pc;
         d_ins <= mem_q;
         o_pc  <= d_pc;
         o_op  <= d_ins[OP_LSB +: 3];
         o_rd  <= d_ins[RD_LSB +: RW];
         o_s1  <= d_ins[S1_LSB +: RW];
         o_s2  <= d_ins[S2_LSB +: RW];
         o_ea  <= d_ins[AW-1:0];
         x_pc  <= o_pc;
         x_op  <= o_op;
         x_rd  <= o_rd;
         x_ea  <= o_ea;
         x_a   <= opa;
         x_b   <= fo_mem ? mem_q[DW-1:0] : opb;
      end
   end

   assign stage_busy = {x_v, o_v, d_v, fetch_go};
   assign ret_valid  = x_v;
   assign ret_pc     = x_pc;
   assign ret_wen    = ex_we;
   assign ret_rd     = x_rd;
   assign ret_data   = ex_res;

   // checker state: last retired instruction
   logic          p_have, p_jmp;
   logic [AW-1:0] p_pc, p_tgt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_have <= 1'b0;
         p_jmp  <= 1'b0;
         p_pc   <= '0;
         p_tgt  <= '0;
      end else if (x_v) begin
         p_have <= 1'b1;
         p_jmp  <= is_jump(x_op);
         p_pc   <= x_pc;
         p_tgt  <= x_ea;
      end
   end

   AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (x_v && p_have) |-> (x_pc == (p_jmp ? p_tgt : p_pc + AW'(1)))); // R4
   AST_JUMP_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (x_v && is_jump(x_op)) |=> !x_v ##1 !x_v ##1 !x_v); // R5
   AST_LOAD_OWNS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (o_v && o_op == OP_LOAD) |=> !d_v); // R6

   if (FORWARD == 0) begin : g_chk_ilk
      AST_INTERLOCK_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
         hz_hold |=> (!x_v && o_v && $stable(o_pc))); // R7
   end else begin : g_chk_fwd
      AST_BYPASS_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
         o_v |=> x_v); // R8
   end
endmodule

// File: tb/ipipe4_ctrl_tb.sv
module ipipe4_ctrl_tb;
   localparam int DW = 8, AW = 4, NREG = 4, RW = 2, IW = 13, DEPTH = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0, run = 1'b0, load_we = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [IW-1:0] load_data = '0;
   logic [RW-1:0] dbg_addr = '0;

   logic [3:0]    busy0, busy1;
   logic          rv0, rv1, rw0, rw1;
   logic [AW-1:0] rp0, rp1;
   logic [RW-1:0] rr0, rr1;
   logic [DW-1:0] rd0, rd1, dbg0, dbg1;

   ipipe4_ctrl #(.DW(DW), .AW(AW), .NREG(NREG), .FORWARD(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .stage_busy(busy0), .ret_valid(rv0), .ret_pc(rp0),
      .ret_wen(rw0), .ret_rd(rr0), .ret_data(rd0), .dbg_addr(dbg_addr), .dbg_data(dbg0));

   ipipe4_ctrl #(.DW(DW), .AW(AW), .NREG(NREG), .FORWARD(0)) u_dut_ilk (
      .clk(clk), .rst_n(rst_n), .run(run), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .stage_busy(busy1), .ret_valid(rv1), .ret_pc(rp1),
      .ret_wen(rw1), .ret_rd(rr1), .ret_data(rd1), .dbg_addr(dbg_addr), .dbg_data(dbg1));

   int checks = 0, fails = 0;
   int cyc = 0;
   logic cnt_en = 1'b0, mon_en = 1'b0;
   always @(posedge clk) cyc <= cnt_en ? cyc + 1 : 0;

   // reference model, index 0 = forwarding, 1 = interlock
   logic [IW-1:0] prog [DEPTH];
   logic [DW-1:0] mreg [2][NREG];
   logic [AW-1:0] mpc [2];
   int  lf [2], la [2], lo [2], nret [2];
   bit  pj [2], pw [2];
   logic [RW-1:0] prd [2];
   bit  blk [2][1024];

   function automatic logic [IW-1:0] enc(int op, int d, int s1, int s2, int ea);
      return {op[2:0], d[1:0], s1[1:0], s2[1:0], ea[3:0]};
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic model_init();
      for (int m = 0; m < 2; m++) begin
         mpc[m] = '0; lf[m] = -1; la[m] = 0; lo[m] = 0; nret[m] = 0;
         pj[m] = 0; pw[m] = 0; prd[m] = '0;
         for (int r = 0; r < NREG; r++) mreg[m][r] = '0;
         for (int c = 0; c < 1024; c++) blk[m][c] = 0;
      end
   endtask

   task automatic step(input int m, input logic [AW-1:0] apc, input logic awen,
                       input logic [RW-1:0] ard, input logic [DW-1:0] adat);
      logic [IW-1:0] w;
      int op, f, a, o, x;
      logic [RW-1:0] d, s1, s2;
      logic [AW-1:0] ea;
      bit ra, rb, wr, st;
      logic [DW-1:0] ev;
      w  = prog[mpc[m]];
      op = int'(w[12:10]); d = w[9:8]; s1 = w[7:6]; s2 = w[5:4]; ea = w[3:0];
      ra = (op == 2 || op == 3 || op == 4);
      rb = (op == 2 || op == 3);
      wr = (op >= 1 && op <= 4);
      f = imax(lf[m] + 1, la[m]);
      if (pj[m]) f = imax(f, lo[m] + 2);
      while (f < 1000 && blk[m][f]) f++;
      a  = imax(f + 1, lo[m]);
      st = (m == 1) && pw[m] && ((ra && prd[m] == s1) || (rb && prd[m] == s2)) && (a == lo[m]);
      o  = a + 1 + (st ? 1 : 0);
      if (st && a + 1 < 1024) blk[m][a + 1] = 1;
      if (op == 1 && o < 1024) blk[m][o] = 1;
      x = o + 1;
      case (op)
         1: ev = prog[ea][DW-1:0];
         2: ev = mreg[m][s1] + mreg[m][s2];
         3: ev = mreg[m][s1] - mreg[m][s2];
         4: ev = mreg[m][s1] + 8'd1;
         default: ev = '0;
      endcase
      checks++;
      if (apc !== mpc[m]) begin
         fails++;
         $display("FAIL R4 mode%0d retire pc actual %0d expected %0d", m, apc, mpc[m]);
      end else if (cyc != x) begin
         fails++;
         $display("FAIL R3/R5/R6/R7/R8 mode%0d pc %0d retire cycle actual %0d expected %0d",
                  m, apc, cyc, x);
      end else if (awen !== wr || (wr && ard !== d) || adat !== ev) begin
         fails++;
         $display("FAIL R2/R9 mode%0d pc %0d actual wen%0d rd%0d data%0h expected wen%0d rd%0d data%0h",
                  m, apc, awen, ard, adat, wr, d, ev);
      end
      if (wr) mreg[m][d] = ev;
      mpc[m] = (op == 5) ? ea : mpc[m] + 4'd1;
      lf[m] = f; la[m] = a; lo[m] = o;
      pj[m] = (op == 5); pw[m] = wr; prd[m] = d;
      nret[m]++;
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (rv0) step(0, rp0, rw0, rr0, rd0);
         if (rv1) step(1, rp1, rw1, rr1, rd1);
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic run_prog(input int target, input bit check_fill);
      int guard;
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      model_init();
      for (int i = 0; i < DEPTH; i++) begin
         load_we = 1'b1; load_addr = AW'(i); load_data = prog[i];
         @(posedge clk); #1;
      end
      load_we = 1'b0;
      run = 1'b1; cnt_en = 1'b1; mon_en = 1'b1;
      if (check_fill) begin
         repeat (4) @(negedge clk);
         chk(busy0 == 4'hF && busy1 == 4'hF, "R3 all stages busy in steady state",
             {busy0, busy1}, 8'hFF);
      end
      guard = 0;
      while ((nret[0] < target || nret[1] < target) && guard < 800) begin
         @(posedge clk); guard++;
      end
      if (guard >= 800) chk(1'b0, "R3 program watchdog retire count", nret[0], target);
      #1 run = 1'b0;
      repeat (10) @(posedge clk);
      #1 mon_en = 1'b0; cnt_en = 1'b0;
      chk(busy0 == 4'h0 && busy1 == 4'h0, "R10 pipeline drained with run low",
          {busy0, busy1}, 0);
      for (int r = 0; r < NREG; r++) begin
         dbg_addr = RW'(r); #1;
         chk(dbg0 === mreg[0][r], "R9 final register forwarding mode", dbg0, mreg[0][r]);
         chk(dbg1 === mreg[1][r], "R9 final register interlock mode", dbg1, mreg[1][r]);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
   end

   initial begin
      void'($urandom(32'd4021));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy0 == 4'h0 && busy1 == 4'h0, "R1 stage_busy after reset", {busy0, busy1}, 0);
      chk(!rv0 && !rv1, "R1 ret_valid after reset", {rv0, rv1}, 0);
      for (int r = 0; r < NREG; r++) begin
         dbg_addr = RW'(r); #1;
         chk(dbg0 == '0 && dbg1 == '0, "R1 register after reset", {dbg0, dbg1}, 0);
      end

      // straight-line independent increments then a self jump (R3, R5)
      for (int i = 0; i < DEPTH; i++) prog[i] = enc(0, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) prog[i] = enc(4, (i % 3) + 1, 0, 0, 0);
      prog[8] = enc(5, 0, 0, 0, 8);
      run_prog(14, 1'b1);

      // back-to-back dependencies (R7, R8) and unused opcodes (R2)
      for (int i = 0; i < DEPTH; i++) prog[i] = enc(0, 0, 0, 0, 0);
      prog[0] = enc(4, 1, 0, 0, 0);
      prog[1] = enc(2, 2, 1, 1, 0);
      prog[2] = enc(3, 3, 2, 1, 0);
      prog[3] = enc(6, 1, 1, 1, 9);
      prog[4] = enc(4, 3, 3, 0, 0);
      prog[5] = enc(2, 0, 3, 2, 0);
      prog[6] = enc(7, 2, 0, 0, 0);
      prog[7] = enc(5, 0, 0, 0, 7);
      run_prog(12, 1'b0);

      // loads take the memory from fetch (R6), then a dependent add
      for (int i = 0; i < DEPTH; i++) prog[i] = enc(0, 0, 0, 0, 0);
      prog[0]  = enc(1, 1, 0, 0, 12);
      prog[1]  = enc(1, 2, 0, 0, 13);
      prog[2]  = enc(2, 3, 1, 2, 0);
      prog[3]  = enc(1, 0, 0, 0, 14);
      prog[4]  = enc(3, 0, 0, 3, 0);
      prog[5]  = enc(5, 0, 0, 0, 5);
      prog[12] = 13'h0A5;
      prog[13] = 13'h1F3;
      prog[14] = 13'h1FF;
      run_prog(12, 1'b0);

      // jump skips code that must never retire (R5)
      for (int i = 0; i < DEPTH; i++) prog[i] = enc(4, 1, 1, 0, 0);
      prog[0] = enc(4, 2, 2, 0, 0);
      prog[1] = enc(5, 0, 0, 0, 9);
      prog[9] = enc(4, 3, 3, 0, 0);
      prog[10] = enc(5, 0, 0, 0, 0);
      run_prog(16, 1'b0);

      // constrained random programs
      for (int t = 0; t < 10; t++) begin
         for (int i = 0; i < DEPTH; i++)
            prog[i] = enc($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
                          $urandom_range(0, 3), $urandom_range(0, 15));
         run_prog(30, 1'b0);
      end

      summary();
   end
endmodule